// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block sits beside a small 8-bit processor core and decides when the core leaves its program to run an interrupt handler, and which one. Up to 21 request lines feed it. Requests on lines 1 and above are captured into pending bits. A pending bit can only be taken when its own enable bit is set and the single global enable flag is set. A take happens only at an instruction boundary, which the core marks with a completion strobe. The lowest-numbered eligible line wins. The block then emits a one-cycle take pulse, a word address of twice the winning line number, and an acknowledge pulse to that line.

On every ordinary take, the controller asks the core to push its return address. In the same step it clears the global flag, so later requests wait as pending until the core signals a return from interrupt. The core can also set or clear the flag with explicit strobes. Setting it inside a handler allows nesting. Line 0 is the reset source. It is never masked and never waits for a boundary. It forces vector 0, clears the global flag and throws away every pending request. No other status is saved or restored here.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After the hardware reset input `rst_n` is released, `takeIrq`, `pushPc`, `vecAddr` and `irqAck` are all zero, and the global flag and every enable bit are clear, so no request is taken until software enables it.
- R2: A take of line n drives `vecAddr` to the word address 2*n. With 21 lines, `vecAddr` is 6 bits wide and the highest line, 20, gives 0x28.
- R3: When several pending and enabled lines are eligible at once, the line with the lowest number is taken first. The others stay pending.
- R4: Line n (for n from 1 to 20) is eligible only when it is pending, bit n of the enable mask is set and the global flag is set. Writing `maskWrData` with `maskWrEn` high replaces the whole mask, and bit 0 of the mask has no effect.
- R5: An ordinary take happens only at the clock edge that ends a cycle with `instrDone` high. Its outputs appear in the following cycle and last exactly one cycle. While `instrDone` stays low, nothing is taken.
- R6: On an ordinary take, `pushPc` and `takeIrq` are high together and `irqAck` is one-hot on the winning line. The winner's pending bit is cleared, and the global flag is cleared at the same edge.
- R7: A request that arrives while the global flag is clear, or while its enable bit is clear, stays pending. It is taken once `retiStrobe` or `gieSet` sets the flag and a boundary follows.
- R8: `gieClr` clears the global flag. `gieClr` takes priority over a `gieSet` or `retiStrobe` in the same cycle, and it blocks a take that would otherwise happen at that edge. The blocked request stays pending. Setting the flag inside a handler lets a further request be taken before the return.
- R9: A high `irqReq[0]` causes a take at the next edge regardless of the mask, the global flag or `instrDone`. That take has `vecAddr` = 0, `irqAck[0]` high and `pushPc` low, and it clears the global flag and all pending bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset of the controller's registers |
| irqReq | input | 21 | Request lines; bit 0 is the reset source |
| maskWrEn | input | 1 | Load strobe for the per-line enable mask |
| maskWrData | input | 21 | New enable mask value |
| gieSet | input | 1 | Sets the global enable flag |
| gieClr | input | 1 | Clears the global enable flag; wins over set and take |
| retiStrobe | input | 1 | Return-from-interrupt; sets the global enable flag |
| instrDone | input | 1 | Current instruction has completed (boundary) |
| takeIrq | output | 1 | One-cycle pulse: the core must vector now |
| pushPc | output | 1 | One-cycle pulse: push the return address (ordinary takes only) |
| vecAddr | output | 6 | Word address of the selected vector slot |
| irqAck | output | 21 | One-hot acknowledge pulse to the taken line |

## Verification
Several properties are checked on every cycle. The acknowledge is one-hot and matches the take pulse. The vector equals twice the acknowledged line. An ordinary take leaves the global flag clear, follows a boundary strobe and never coincides with a reset take. An explicit clear always lands. Other behaviour depends on history and only the bench's scenarios can show it. That covers which line wins among several pending ones, requests held across a long disabled window and released by a return, the clear strobe blocking a take in its own cycle, and nesting after a set inside a handler. The bench's reference model follows the pending set and flag over time and compares every output on every cycle.

// File: rtl/irq_pkg.sv
package irq_pkg;

  // Strobes from the control decision to the datapath registers.
  typedef struct packed {
    logic takeVec;    // ordinary vectored take at this edge
    logic takeReset;  // non-maskable reset take at this edge
    logic gieToZero;  // global flag goes low
    logic gieToOne;   // global flag goes high
  } ctlStrobes_t;

endpackage

// File: rtl/irq_control.sv
module irq_control
  import irq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        resetReq,
  input  logic        instrDone,
  input  logic        gieSet,
  input  logic        gieClr,
  input  logic        retiStrobe,
  input  logic        gieQ,
  input  logic        anyCand,
  output ctlStrobes_t ctl
);

  always_comb begin
    ctl.takeReset = resetReq;
    ctl.takeVec   = !resetReq && instrDone && gieQ && anyCand && !gieClr;
    ctl.gieToZero = ctl.takeReset || ctl.takeVec || gieClr;
    ctl.gieToOne  = (gieSet || retiStrobe) && !ctl.gieToZero;
  end

  // R8: an explicit clear always leaves the flag low at the next cycle
  assert_clr_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    gieClr |=> !gieQ);

  // R7: a return with no competing clear or take raises the flag
  assert_reti_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (retiStrobe && !gieClr && !resetReq && !(instrDone && gieQ && anyCand)) |=> gieQ);

endmodule

// File: rtl/irq_datapath.sv
module irq_datapath
  import irq_pkg::*;
#(
  parameter int NUM_SRC = 21
) (
  input  logic               clk,
  input  logic               rst_n,
  input  ctlStrobes_t        ctl,
  input  logic [NUM_SRC-1:0] irqReq,
  input  logic               maskWrEn,
  input  logic [NUM_SRC-1:0] maskWrData,
  output logic               gieQ,
  output logic               anyCand,
  output logic               takeIrq,
  output logic               pushPc,
  output logic [$clog2(2*NUM_SRC)-1:0] vecAddr,
  output logic [NUM_SRC-1:0] irqAck
);

  localparam int VEC_W = $clog2(2*NUM_SRC);
  localparam int IDX_W = $clog2(NUM_SRC);

  logic [NUM_SRC-1:0] pendQ;
  logic [NUM_SRC-1:0] maskQ;
  logic [NUM_SRC-1:0] cand;
  logic [NUM_SRC-1:0] winHot;
  logic [IDX_W-1:0]   winIdx;
  logic [NUM_SRC-1:0] reqMaskable;

  // line 0 never enters the pending set or the mask decision
  assign reqMaskable = irqReq & ~NUM_SRC'(1);
  assign cand        = pendQ & maskQ & ~NUM_SRC'(1);
  assign anyCand     = |cand;
  assign winHot      = cand & (~cand + NUM_SRC'(1));

  always_comb begin
    winIdx = '0;
    for (int i = NUM_SRC-1; i >= 1; i--) begin
      if (cand[i]) winIdx = IDX_W'(i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pendQ   <= '0;
      maskQ   <= '0;
      gieQ    <= 1'b0;
      takeIrq <= 1'b0;
      pushPc  <= 1'b0;
      vecAddr <= '0;
      irqAck  <= '0;
    end else begin
      if (maskWrEn) maskQ <= maskWrData;

      if (ctl.gieToZero)     gieQ <= 1'b0;
      else if (ctl.gieToOne) gieQ <= 1'b1;

      if (ctl.takeReset) begin
        pendQ   <= '0;
        takeIrq <= 1'b1;
        pushPc  <= 1'b0;
        vecAddr <= '0;
        irqAck  <= NUM_SRC'(1);
      end else if (ctl.takeVec) begin
        pendQ   <= (pendQ & ~winHot) | reqMaskable;
        takeIrq <= 1'b1;
        pushPc  <= 1'b1;
        vecAddr <= VEC_W'({winIdx, 1'b0});
        irqAck  <= winHot;
      end else begin
        pendQ   <= pendQ | reqMaskable;
        takeIrq <= 1'b0;
        pushPc  <= 1'b0;
        vecAddr <= '0;
        irqAck  <= '0;
      end
    end
  end

  // R6: acknowledge is one-hot and present exactly when a take is signalled
  assert_ack_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irqAck) && ((|irqAck) == takeIrq));

  // R6: an ordinary take leaves the global flag clear
  assert_take_clears_gie_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (takeIrq && pushPc) |-> !gieQ);

  // R9: reset take never asks for a push and uses slot zero
  assert_reset_take_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irqAck[0] |-> (!pushPc && vecAddr == '0 && !gieQ));

  // R2: the vector matches the acknowledged line
  always_ff @(posedge clk) begin
    if (rst_n && takeIrq) begin
      for (int i = 0; i < NUM_SRC; i++) begin
        if (irqAck[i]) begin
          assert_vec_matches_ack_R2: assert (vecAddr == VEC_W'(2*i));
        end
      end
    end
  end

endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import irq_pkg::*;
#(
  parameter int NUM_SRC = 21,
  localparam int VEC_W = $clog2(2*NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irqReq,
  input  logic               maskWrEn,
  input  logic [NUM_SRC-1:0] maskWrData,
  input  logic               gieSet,
  input  logic               gieClr,
  input  logic               retiStrobe,
  input  logic               instrDone,
  output logic               takeIrq,
  output logic               pushPc,
  output logic [VEC_W-1:0]   vecAddr,
  output logic [NUM_SRC-1:0] irqAck
);

  ctlStrobes_t ctl;
  logic        gieQ;
  logic        anyCand;

  irq_control u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .resetReq   (irqReq[0]),
    .instrDone  (instrDone),
    .gieSet     (gieSet),
    .gieClr     (gieClr),
    .retiStrobe (retiStrobe),
    .gieQ       (gieQ),
    .anyCand    (anyCand),
    .ctl        (ctl)
  );

  irq_datapath #(.NUM_SRC(NUM_SRC)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl        (ctl),
    .irqReq     (irqReq),
    .maskWrEn   (maskWrEn),
    .maskWrData (maskWrData),
    .gieQ       (gieQ),
    .anyCand    (anyCand),
    .takeIrq    (takeIrq),
    .pushPc     (pushPc),
    .vecAddr    (vecAddr),
    .irqAck     (irqAck)
  );

  // R5: an ordinary take follows a boundary cycle
  assert_take_at_boundary_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (takeIrq && pushPc) |-> $past(instrDone));

endmodule

// File: tb/vec_irq_ctrl_tb.sv
module vec_irq_ctrl_tb;

  localparam int NS = 21;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] irqReq = '0;
  logic          maskWrEn = 1'b0;
  logic [NS-1:0] maskWrData = '0;
  logic          gieSet = 1'b0, gieClr = 1'b0, retiStrobe = 1'b0, instrDone = 1'b0;
  logic          takeIrq, pushPc;
  logic [5:0]    vecAddr;
  logic [NS-1:0] irqAck;

  int    nChecks = 0;
  int    nFails  = 0;
  string curReq  = "R1";
  bit    done    = 1'b0;

  always #5 clk = ~clk;

  vec_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .irqReq(irqReq), .maskWrEn(maskWrEn),
    .maskWrData(maskWrData), .gieSet(gieSet), .gieClr(gieClr),
    .retiStrobe(retiStrobe), .instrDone(instrDone), .takeIrq(takeIrq),
    .pushPc(pushPc), .vecAddr(vecAddr), .irqAck(irqAck)
  );

  // Behavioural reference: sets of pending/enabled line numbers and a flag.
  bit          mPend[NS];
  bit          mEn[NS];
  bit          mGie;
  bit          mTake, mPush;
  int          mVec;
  int          mAckLine;

  always @(posedge clk) begin
    int win;
    bit fire;
    if (!rst_n) begin
      foreach (mPend[i]) begin mPend[i] = 0; mEn[i] = 0; end
      mGie = 0; mTake = 0; mPush = 0; mVec = 0; mAckLine = -1;
    end else begin
      if (irqReq[0]) begin
        mTake = 1; mPush = 0; mVec = 0; mAckLine = 0;
        foreach (mPend[i]) mPend[i] = 0;
        mGie = 0;
      end else begin
        win = -1;
        for (int i = 1; i < NS; i++)
          if (win < 0 && mPend[i] && mEn[i]) win = i;
        fire = instrDone && mGie && (win > 0) && !gieClr;
        mTake = fire; mPush = fire;
        mVec = fire ? 2*win : 0;
        mAckLine = fire ? win : -1;
        if (fire) mPend[win] = 0;
        for (int i = 1; i < NS; i++) if (irqReq[i]) mPend[i] = 1;
        if (gieClr || fire) mGie = 0;
        else if (gieSet || retiStrobe) mGie = 1;
      end
      if (maskWrEn) foreach (mEn[i]) mEn[i] = maskWrData[i];
    end
  end

  // Every-cycle comparison of all outputs against the reference.
  always @(negedge clk) begin
    logic [NS-1:0] expAck;
    if (rst_n && !done) begin
      expAck = (mAckLine >= 0) ? (NS'(1) << mAckLine) : '0;
      nChecks++;
      if (takeIrq !== mTake || pushPc !== mPush || vecAddr !== 6'(mVec) || irqAck !== expAck) begin
        nFails++;
        $display("FAIL %s cycle compare: take=%0b push=%0b vec=%0h ack=%0h expected take=%0b push=%0b vec=%0h ack=%0h",
                 curReq, takeIrq, pushPc, vecAddr, irqAck, mTake, mPush, mVec, expAck);
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  // drive a one-cycle pattern, then return at the negedge where its effect shows
  task automatic pulse(input logic [NS-1:0] req, input bit done_, input bit s, input bit c, input bit r);
    irqReq = req; instrDone = done_; gieSet = s; gieClr = c; retiStrobe = r;
    @(negedge clk);
    irqReq = '0; instrDone = 0; gieSet = 0; gieClr = 0; retiStrobe = 0;
  endtask

  task automatic writeMask(input logic [NS-1:0] m);
    maskWrEn = 1; maskWrData = m;
    @(negedge clk);
    maskWrEn = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    curReq = "R1";
    chk(takeIrq == 0 && pushPc == 0 && irqAck == 0 && vecAddr == 0, "R1 idle outputs", irqAck, 0);

    // R1/R4: request with everything disabled is not taken
    curReq = "R4";
    pulse(NS'(1) << 3, 1, 0, 0, 0);
    pulse('0, 1, 0, 0, 0);
    chk(takeIrq == 0, "R4 no take while disabled", takeIrq, 0);
    // mask bit 0 alone does not enable line 3
    writeMask(NS'(1));
    pulse('0, 0, 1, 0, 0);
    pulse('0, 1, 0, 0, 0);
    chk(takeIrq == 0, "R4 mask bit0 has no effect", takeIrq, 0);

    // R7: flag on, line 3 still pending from earlier; enabling it now lets it go
    curReq = "R7";
    writeMask(NS'(1) << 3);
    pulse('0, 1, 0, 0, 0);
    chk(takeIrq && pushPc && vecAddr == 6 && irqAck == (NS'(1) << 3), "R7 held request taken", vecAddr, 6);
    curReq = "R6";
    pulse('0, 1, 0, 0, 0);
    chk(takeIrq == 0, "R6 pending cleared and flag cleared", takeIrq, 0);

    // R3: lines 5 and 2 together; 2 first, then 5 after return
    curReq = "R3";
    writeMask({NS{1'b1}});
    pulse((NS'(1) << 5) | (NS'(1) << 2), 0, 0, 0, 1);
    pulse('0, 1, 0, 0, 0);
    chk(takeIrq && vecAddr == 4, "R3 lowest line first", vecAddr, 4);
    // R7: arrived during handler, flag clear; stays pending
    pulse('0, 1, 0, 0, 0);
    chk(takeIrq == 0, "R7 waits for return", takeIrq, 0);
    pulse('0, 0, 0, 0, 1);
    pulse('0, 1, 0, 0, 0);
    chk(takeIrq && vecAddr == 10, "R3 second line after return", vecAddr, 10);

    // R5: pending and enabled, no boundary for many cycles
    curReq = "R5";
    pulse(NS'(1) << 7, 0, 0, 0, 1);
    for (int k = 0; k < 6; k++) begin
      pulse('0, 0, 0, 0, 0);
      chk(takeIrq == 0, "R5 no boundary no take", takeIrq, 0);
    end
    pulse('0, 1, 0, 0, 0);
    chk(takeIrq && vecAddr == 14, "R5 taken at boundary", vecAddr, 14);
    pulse('0, 0, 0, 0, 0);
    chk(takeIrq == 0, "R5 one-cycle pulse", takeIrq, 0);

    // R8: clear in the same cycle as boundary blocks take; set+clear leaves it clear
    curReq = "R8";
    pulse(NS'(1) << 9, 0, 0, 0, 1);
    pulse('0, 1, 0, 1, 0);
    chk(takeIrq == 0, "R8 clear blocks take", takeIrq, 0);
    pulse('0, 0, 1, 1, 0);
    pulse('0, 1, 0, 0, 0);
    chk(takeIrq == 0, "R8 clear beats set", takeIrq, 0);
    pulse('0, 0, 1, 0, 0);
    pulse('0, 1, 0, 0, 0);
    chk(takeIrq && vecAddr == 18, "R8 blocked request kept", vecAddr, 18);
    // nesting: set inside handler, a later line is taken before return
    pulse(NS'(1) << 12, 0, 1, 0, 0);
    pulse('0, 1, 0, 0, 0);
    chk(takeIrq && vecAddr == 24, "R8 nested take", vecAddr, 24);

    // R2: highest line
    curReq = "R2";
    pulse(NS'(1) << 20, 0, 0, 0, 1);
    pulse('0, 1, 0, 0, 0);
    chk(takeIrq && vecAddr == 6'h28 && irqAck[20], "R2 top line vector", vecAddr, 'h28);

    // R9: reset line, flag clear, no boundary, no mask
    curReq = "R9";
    writeMask('0);
    pulse(NS'(1) << 4, 0, 0, 0, 1);
    pulse(NS'(1), 0, 0, 0, 0);
    chk(takeIrq && !pushPc && vecAddr == 0 && irqAck == NS'(1), "R9 reset take", irqAck, 1);
    writeMask({NS{1'b1}});
    pulse('0, 0, 1, 0, 0);
    pulse('0, 1, 0, 0, 0);
    chk(takeIrq == 0, "R9 pending dropped by reset", takeIrq, 0);

    idle(3);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      nFails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

endmodule